// File: doc/BRIEF.md
# Timed Parallel Control-Bus Writer

This block connects a host processor to a slow, write-only parallel bus that fans out to many sound-generating modules. The host fills four byte-wide staging registers that together form a 16-bit bus address and a 16-bit data word. Writing the data low byte fires a transfer. The block takes a snapshot of the full word at that moment and drives it onto the bus. It keeps the write strobe low for a settle interval and then raises it for a strobe interval. Both intervals are set in nanoseconds and turned into clock cycles from the clock frequency. The default is 10 us each, so one complete transfer lasts about 20 us.

On the bus, address bits 15..8 name one of up to 256 receiving modules. Bits 7..0 name one of up to 256 function registers inside that module. A receiver whose module number matches captures the data into the addressed function register when the strobe arrives. A host normally issues no more than one word every 10 to 20 us. For the case where a word arrives while a transfer is still under way, a single holding slot stores it. A sticky overrun flag records any trigger that arrives while the holding slot is already full.

Top module: `ctrl_bus_writer`

## Requirements
- R1: After reset, host_busy, host_overrun and bus_wen are 0, and bus_addr and bus_data are 0.
- R2: host_sel selects the staging byte as follows: 0 is address[15:8], 1 is address[7:0], 2 is data[15:8] and 3 is data[7:0]. Writes with sel 0, 1 or 2 only update staged bytes and cause no bus activity. Staged bytes keep their values across transfers.
- R3: When the block is idle, a write with sel 3 puts the staged address and data, with the new low data byte, onto bus_addr and bus_data at that same clock edge, with bus_wen still 0.
- R4: From the edge that loads the bus, bus_wen stays 0 for SETTLE_CYC cycles and is then 1 for exactly STROBE_CYC cycles. Each of these counts is the interval in ns times CLK_FREQ_HZ / 1e9, rounded up, with a minimum of 1.
- R5: bus_addr and bus_data hold steady while bus_wen is 1. They also hold at the edge where bus_wen falls, so they change only after a cycle with bus_wen at 0.
- R6: host_busy is 1 from the trigger edge until the last strobe cycle of the final transfer has ended, and also while a trigger is held. bus_wen is never 1 while host_busy is 0.
- R7: Host writes to staging registers during a transfer leave the bus word of that transfer unchanged.
- R8: A trigger arriving while a transfer is active and the holding slot is empty is stored. It starts one cycle after the current strobe ends, so bus_wen stays low for SETTLE_CYC+1 cycles between the two strobes.
- R9: A trigger arriving while a transfer is active and the holding slot is full is dropped and sets host_overrun. host_overrun stays 1 until reset.
- R10: A receiver with module number M latches bus_data into function register address[7:0] only when address[15:8] equals M. Receivers with other numbers keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe for one staging byte |
| host_sel | input | 2 | Staging byte select (3 = data low, the trigger) |
| host_wdata | input | 8 | Host write byte |
| host_busy | output | 1 | Transfer active or held |
| host_overrun | output | 1 | Sticky: a trigger was dropped |
| bus_addr | output | 16 | Bus address, module in [15:8], function in [7:0] |
| bus_data | output | 16 | Bus data word |
| bus_wen | output | 1 | Bus write strobe, active high |

## Verification
From idle, a trigger write shows on bus_addr and bus_data at the edge that accepts it. bus_wen rises SETTLE_CYC edges later and falls STROBE_CYC edges after that. A held trigger adds exactly one idle cycle before its own settle interval. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the trigger or from the end of the previous strobe, and compares each count with SETTLE_CYC, SETTLE_CYC+1 or STROBE_CYC, all computed from the clock frequency and the interval parameters. It sweeps all 256 function numbers across two matching module numbers and one number that no receiver matches. Receiver contents and strobe counts are checked after each strobe has ended, when any capture must already have taken place.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = ADDR_W + DATA_W;
  localparam int NUM_LANES = WORD_W / BYTE_W;
  localparam int SEL_W     = $clog2(NUM_LANES);

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_STROBE = 2'd2
  } phase_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_word_t;
endpackage

// File: rtl/cbw_rst_sync.sv
module cbw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cbw_stage.sv
module cbw_stage import cbw_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic              trig,
  output bus_word_t         trig_word
);
  localparam int TRIG_LANE = NUM_LANES - 1;

  logic [WORD_W-1:0] snap_flat;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic              wr_en;
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;

    assign wr_en  = host_we && (host_sel == SEL_W'(i));
    assign byte_d = wr_en ? host_wdata : byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (wr_en) begin
        byte_q <= byte_d;
      end
    end

    // lane 0 is the most significant byte of the word
    assign snap_flat[(NUM_LANES-1-i)*BYTE_W +: BYTE_W] = byte_d;
  end

  assign trig      = host_we && (host_sel == SEL_W'(TRIG_LANE));
  assign trig_word = bus_word_t'(snap_flat);
endmodule

// File: rtl/cbw_hold.sv
module cbw_hold import cbw_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trig,
  input  bus_word_t trig_word,
  input  logic      active,
  output logic      start,
  output bus_word_t start_word,
  output logic      pending,
  output logic      overrun
);
  logic      pend_q, pend_d;
  logic      ovr_q, ovr_d;
  logic      load_en;
  bus_word_t word_q;

  always_comb begin
    start      = !active && (pend_q || trig);
    start_word = pend_q ? word_q : trig_word;
  end

  always_comb begin
    pend_d  = pend_q;
    ovr_d   = ovr_q;
    load_en = 1'b0;
    if (!active) begin
      if (pend_q) begin
        if (trig) begin
          load_en = 1'b1;   // held word launches, new trigger takes its slot
        end else begin
          pend_d = 1'b0;
        end
      end
    end else if (trig) begin
      if (pend_q) begin
        ovr_d = 1'b1;
      end else begin
        pend_d  = 1'b1;
        load_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= trig_word;
    end
  end

  assign pending = pend_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/cbw_timer.sv
module cbw_timer import cbw_pkg::*; #(
  parameter int unsigned SETTLE_CYC = 1,
  parameter int unsigned STROBE_CYC = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  bus_word_t start_word,
  output logic      active,
  output bus_word_t bus_word,
  output logic      wen
);
  localparam int unsigned MAX_CYC = (SETTLE_CYC > STROBE_CYC) ? SETTLE_CYC : STROBE_CYC;
  localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wen_q, wen_d;
  logic             load_en;
  bus_word_t        word_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    wen_d   = wen_q;
    load_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETTLE;
          cnt_d   = SETTLE_LAST;
          load_en = 1'b1;
        end
      end
      PH_SETTLE: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = STROBE_LAST;
          wen_d   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          wen_d   = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        wen_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wen_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wen_q   <= wen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= start_word;
    end
  end

  assign active   = (phase_q != PH_IDLE);
  assign bus_word = word_q;
  assign wen      = wen_q;
endmodule

// File: rtl/ctrl_bus_writer.sv
module ctrl_bus_writer import cbw_pkg::*; #(
  parameter int unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned SETTLE_NS   = 10_000,
  parameter int unsigned STROBE_NS   = 10_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic              host_busy,
  output logic              host_overrun,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_wen
);
  localparam longint NS_PER_S   = 64'd1_000_000_000;
  localparam longint SETTLE_RAW = (longint'(CLK_FREQ_HZ) * longint'(SETTLE_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam longint STROBE_RAW = (longint'(CLK_FREQ_HZ) * longint'(STROBE_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam int unsigned SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);
  localparam int unsigned STROBE_CYC = (STROBE_RAW < 1) ? 1 : int'(STROBE_RAW);

  logic      srst_n;
  logic      trig;
  bus_word_t trig_word;
  logic      start;
  bus_word_t start_word;
  logic      pending;
  logic      active;
  bus_word_t out_word;

  cbw_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cbw_stage u_stage (
    .clk        (clk),
    .rst_n      (srst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .trig       (trig),
    .trig_word  (trig_word)
  );

  cbw_hold u_hold (
    .clk        (clk),
    .rst_n      (srst_n),
    .trig       (trig),
    .trig_word  (trig_word),
    .active     (active),
    .start      (start),
    .start_word (start_word),
    .pending    (pending),
    .overrun    (host_overrun)
  );

  cbw_timer #(
    .SETTLE_CYC (SETTLE_CYC),
    .STROBE_CYC (STROBE_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (srst_n),
    .start      (start),
    .start_word (start_word),
    .active     (active),
    .bus_word   (out_word),
    .wen        (bus_wen)
  );

  assign host_busy = active || pending;
  assign bus_addr  = out_word.addr;
  assign bus_data  = out_word.data;
endmodule

// File: rtl/cbw_checker.sv
module cbw_checker #(
  parameter int unsigned STROBE_CYC = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_busy,
  input logic        host_overrun,
  input logic        bus_wen,
  input logic [15:0] bus_addr,
  input logic [15:0] bus_data
);
  int unsigned hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 0;
    end else begin
      hi_cnt <= bus_wen ? hi_cnt + 1 : 0;
    end
  end

  assert_wen_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen |-> host_busy);

  assert_word_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bus_addr) || !$stable(bus_data)) |-> !$past(bus_wen));

  assert_strobe_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wen) |-> (hi_cnt == STROBE_CYC));

  assert_strobe_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen |-> (hi_cnt < STROBE_CYC));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_overrun |=> host_overrun);
endmodule

bind ctrl_bus_writer cbw_checker #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_busy    (host_busy),
  .host_overrun (host_overrun),
  .bus_wen      (bus_wen),
  .bus_addr     (bus_addr),
  .bus_data     (bus_data)
);

// File: tb/sim_ctrl_bus_writer.sv
module sim_rx #(
  parameter logic [7:0] MOD_ID = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wen,
  input  logic [15:0] addr,
  input  logic [15:0] data,
  input  logic [7:0]  rd_fn,
  output logic [15:0] rd_val,
  output int          hits
);
  logic [15:0] regs [256];
  logic        wen_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= '0;
      wen_prev <= 1'b0;
      hits     <= 0;
    end else begin
      wen_prev <= wen;
      if (wen && !wen_prev && addr[15:8] == MOD_ID) begin
        regs[addr[7:0]] <= data;
        hits            <= hits + 1;
      end
    end
  end

  assign rd_val = regs[rd_fn];
endmodule

module sim_ctrl_bus_writer;
  localparam int unsigned CLK_HZ = 200_000_000;
  localparam int unsigned S_NS   = 40;
  localparam int unsigned W_NS   = 30;
  localparam int S = int'((longint'(CLK_HZ) * S_NS + 999_999_999) / 1_000_000_000);
  localparam int W = int'((longint'(CLK_HZ) * W_NS + 999_999_999) / 1_000_000_000);
  localparam logic [7:0] MOD_A = 8'h3A;
  localparam logic [7:0] MOD_B = 8'hC5;
  localparam logic [7:0] MOD_N = 8'h3B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_busy, host_overrun, bus_wen;
  logic [15:0] bus_addr, bus_data;
  logic [7:0]  rd_fn_a = '0, rd_fn_b = '0;
  logic [15:0] rd_a, rd_b;
  int          hits_a, hits_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_a [256];
  logic [15:0] exp_b [256];

  always #2.5 clk = ~clk;

  ctrl_bus_writer #(.CLK_FREQ_HZ(CLK_HZ), .SETTLE_NS(S_NS), .STROBE_NS(W_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_busy(host_busy), .host_overrun(host_overrun),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_wen(bus_wen));

  sim_rx #(.MOD_ID(MOD_A)) u_rx_a (.clk(clk), .rst_n(rst_n), .wen(bus_wen),
    .addr(bus_addr), .data(bus_data), .rd_fn(rd_fn_a), .rd_val(rd_a), .hits(hits_a));
  sim_rx #(.MOD_ID(MOD_B)) u_rx_b (.clk(clk), .rst_n(rst_n), .wen(bus_wen),
    .addr(bus_addr), .data(bus_data), .rd_fn(rd_fn_b), .rd_val(rd_b), .hits(hits_b));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic stage(input logic [15:0] a, input logic [7:0] dh);
    hw(2'd0, a[15:8]);
    hw(2'd1, a[7:0]);
    hw(2'd2, dh);
  endtask

  // Called at a falling edge; counts falling edges until the strobe rises and while it is high.
  task automatic measure(input logic [15:0] ea, input logic [15:0] ed, input int elo, input string tag);
    int lo = 0;
    int hi = 0;
    bit moved = 0;
    logic [15:0] ra, rd;
    while (!bus_wen && lo < 5000) begin @(negedge clk); lo++; end
    chk(lo == elo, {tag, " R4/R8 settle cycles"}, lo, elo);
    ra = bus_addr; rd = bus_data;
    chk(ra == ea, {tag, " R3 bus address"}, ra, ea);
    chk(rd == ed, {tag, " R3 bus data"}, rd, ed);
    while (bus_wen && hi < 5000) begin
      @(negedge clk); hi++;
      if (bus_addr != ra || bus_data != rd) moved = 1;
    end
    chk(hi == W, {tag, " R4 strobe cycles"}, hi, W);
    chk(!moved, {tag, " R5 word held through strobe fall"}, {bus_addr, bus_data}, {ra, rd});
  endtask

  task automatic note_write(input logic [15:0] a, input logic [15:0] d);
    if (a[15:8] == MOD_A) exp_a[a[7:0]] = d;
    if (a[15:8] == MOD_B) exp_b[a[7:0]] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin exp_a[i] = '0; exp_b[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!host_busy, "R1 busy after reset", host_busy, 0);
    chk(!host_overrun, "R1 overrun after reset", host_overrun, 0);
    chk(!bus_wen, "R1 strobe after reset", bus_wen, 0);
    chk(bus_addr == 0 && bus_data == 0, "R1 bus word after reset", {bus_addr, bus_data}, 0);

    // R2 non-trigger lanes cause no bus activity
    begin
      bit act = 0;
      stage(16'h3A10, 8'h77);
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (bus_wen || host_busy || bus_addr != 0) act = 1;
      end
      chk(!act, "R2 staging only, no activity", act, 0);
    end

    // R3, R4, R6 single transfer from idle
    hw(2'd3, 8'h99);
    chk(bus_addr == 16'h3A10 && bus_data == 16'h7799, "R3 word loaded at trigger edge",
        {bus_addr, bus_data}, 32'h3A10_7799);
    chk(!bus_wen, "R3 strobe low at load", bus_wen, 0);
    chk(host_busy, "R6 busy after trigger", host_busy, 1);
    measure(16'h3A10, 16'h7799, S, "single");
    note_write(16'h3A10, 16'h7799);
    chk(!host_busy, "R6 idle after strobe end", host_busy, 1);
    rd_fn_a = 8'h10; #0.1;
    chk(rd_a == 16'h7799, "R10 receiver A latched", rd_a, 16'h7799);

    // R10 sweep over all function numbers and three module numbers
    for (int f = 0; f < 256; f++) begin
      logic [7:0]  m;
      logic [15:0] a, d;
      int ha, hb;
      m = (f % 3 == 0) ? MOD_A : ((f % 3 == 1) ? MOD_B : MOD_N);
      a = {m, 8'(f)};
      d = 16'((f * 16'h0139) ^ 16'hA55A);
      ha = hits_a; hb = hits_b;
      stage(a, d[15:8]);
      hw(2'd3, d[7:0]);
      measure(a, d, S, "sweep");
      note_write(a, d);
      chk(hits_a == ha + ((m == MOD_A) ? 1 : 0), "R10 receiver A strobe count", hits_a, ha);
      chk(hits_b == hb + ((m == MOD_B) ? 1 : 0), "R10 receiver B strobe count", hits_b, hb);
    end
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) begin
        rd_fn_a = 8'(i); rd_fn_b = 8'(i); #0.1;
        if (rd_a != exp_a[i] || rd_b != exp_b[i]) bad++;
      end
      chk(bad == 0, "R10 receiver contents after sweep", bad, 0);
    end

    // R7 snapshot: staging writes during a transfer do not disturb it; R2 staged bytes persist
    @(negedge clk);
    stage(16'hC5EE, 8'h12);
    hw(2'd3, 8'h34);
    stage(16'h3A44, 8'h56);
    measure(16'hC5EE, 16'h1234, S - 6, "snapshot");
    note_write(16'hC5EE, 16'h1234);
    hw(2'd3, 8'h78);
    chk(bus_addr == 16'h3A44 && bus_data == 16'h5678, "R2/R7 new staged word on next trigger",
        {bus_addr, bus_data}, 32'h3A44_5678);
    measure(16'h3A44, 16'h5678, S, "restaged");
    note_write(16'h3A44, 16'h5678);

    // R8 held trigger runs after the current strobe with SETTLE+1 gap
    @(negedge clk);
    stage(16'hC501, 8'hAB);
    hw(2'd3, 8'h01);
    stage(16'hC502, 8'hCD);
    hw(2'd3, 8'h02);
    chk(host_busy && !host_overrun, "R8 second trigger held, no overrun", host_overrun, 0);
    measure(16'hC501, 16'hAB01, S - 8, "first");
    chk(host_busy, "R6/R8 busy while held word waits", host_busy, 1);
    measure(16'hC502, 16'hCD02, S + 1, "held");
    chk(!host_busy, "R8 idle after held transfer", host_busy, 1);
    rd_fn_b = 8'h02; #0.1;
    chk(rd_b == 16'hCD02, "R8 held word latched", rd_b, 16'hCD02);

    // R9 third trigger while slot full is dropped
    begin
      int ha;
      @(negedge clk);
      stage(16'h3A80, 8'h5E);
      ha = hits_a;
      hw(2'd3, 8'h11);
      hw(2'd3, 8'h22);
      chk(!host_overrun, "R9 no overrun with empty slot", host_overrun, 0);
      hw(2'd3, 8'h33);
      chk(host_overrun, "R9 overrun on full slot", host_overrun, 1);
      measure(16'h3A80, 16'h5E11, S - 4, "ovr first");
      measure(16'h3A80, 16'h5E22, S + 1, "ovr held");
      repeat (2 * (S + W)) @(negedge clk);
      chk(hits_a == ha + 2, "R9 dropped word never strobed", hits_a, ha + 2);
      rd_fn_a = 8'h80; #0.1;
      chk(rd_a == 16'h5E22, "R9 last latched word is the held one", rd_a, 16'h5E22);
      stage(16'h3A81, 8'h00);
      hw(2'd3, 8'h01);
      measure(16'h3A81, 16'h0001, S, "after ovr");
      chk(host_overrun, "R9 overrun sticky", host_overrun, 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule